// File: doc/BRIEF.md
# Processor Power-Up Reset Sequencer

This block takes a processor core from a cold reset to its first instruction fetch. It runs a fixed series of bring-up phases. First it captures the configuration when the power-good input rises. Then it waits for the system clock to start, waits for the clock to ramp and lock, and starts the array self-test. After that it starts the instruction-cache load from serial ROM and allows a minimum load time. Finally it issues a fetch-start strobe with the boot address, and after a further hold-off it enables off-chip commands.

The reset input is an asynchronous active-low pin. It passes through a five-stage synchronizer, and the sequencer acts only on the synchronizer's output. The clock generator, the self-test engine and the serial-ROM loader sit outside this block. Each of them talks to the sequencer through a start strobe and a done (or fail) input. Every delay is a parameter. The cache-load minimum is derived from a fixed part plus a per-line part multiplied by the line count.

Top module: `boot_sequencer`

## Requirements
- R1: The core logic stays in reset while `rst_n` is low, and for five rising clock edges after `rst_n` is released. The first edge that can act on `dcok` is the sixth edge after release.
- R2: In the idle phase, a rising edge on `dcok` gives a one-cycle `cfg_load_o` pulse. The same edge latches `irq` into `irq_cfg_o`, which then holds that value until the next reset.
- R3: `clk_ramp_o` pulses exactly `CLK_START_DLY` cycles after `cfg_load_o`.
- R4: `bist_start_o` pulses exactly `FRAME_DLY` cycles after `clk_ramp_o`.
- R5: While the sequencer waits for self-test, `bist_done` sampled high with `bist_fail` low gives a `load_start_o` pulse in the next cycle.
- R6: `fetch_o` pulses when two conditions are both met: at least `LOAD_FIXED + LOAD_PER_LINE*CACHE_LINES` cycles have passed since `load_start_o`, and `load_done` has been seen. If `load_done` arrives late, `fetch_o` follows one cycle after it is sampled.
- R7: `fetch_o` is a single-cycle pulse, and `boot_addr_o` equals `BOOT_ADDR` (default 0x780) from that cycle onwards. `done_o` rises with `fetch_o` and stays high until reset.
- R8: `cmd_en_o` rises exactly `CMD_HOLD_DLY` cycles after `fetch_o`, stays high, and is never high without `done_o`.
- R9: `bist_fail` sampled high during the self-test wait sets `fail_o`, which stays high. It takes priority over `bist_done`. After it, no load start, fetch or done follows.
- R10: Pulling `rst_n` low at any point clears every strobe, `irq_cfg_o`, `boot_addr_o`, `cmd_en_o`, `done_o` and `fail_o` on the next clock edge. The sequence then restarts from idle.
- R11: At most one phase strobe is high in any cycle. Each strobe fires once per boot, and `dcok` edges outside the idle phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| dcok | input | 1 | Power-good indication |
| irq | input | IRQ_W | Interrupt lines, read as configuration |
| bist_done | input | 1 | Self-test finished |
| bist_fail | input | 1 | Self-test reported a failure |
| load_done | input | 1 | Serial-ROM cache load finished |
| cfg_load_o | output | 1 | Configuration-load strobe |
| clk_ramp_o | output | 1 | Clock-ramp wait strobe |
| bist_start_o | output | 1 | Self-test start strobe |
| load_start_o | output | 1 | Cache-load start strobe |
| irq_cfg_o | output | IRQ_W | Latched interrupt configuration word |
| cmd_en_o | output | 1 | Off-chip commands allowed |
| fetch_o | output | 1 | Fetch-start strobe |
| boot_addr_o | output | ADDR_W | First fetch address |
| done_o | output | 1 | Bring-up complete |
| fail_o | output | 1 | Self-test failure, sequence halted |

## Verification
The bench builds the block with a clock-start delay of 8, a framing delay of 20, and a hold-off of 12. The load minimum is a fixed 30 plus 5 per line over 4 lines, so 50 cycles. These short values let every phase boundary be measured to the exact cycle, and let a full boot plus the late-load, failure and mid-load-reset cases fit in a few hundred cycles. The address and configuration widths are left at their defaults, so the boot address checked is 0x780.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLKWAIT,
    PH_RAMP,
    PH_SELFTEST,
    PH_LOAD,
    PH_RUN,
    PH_HALT
  } phase_t;
endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_o
);
  logic [STAGES-1:0] chain_q;

  // assertion is immediate, release walks through every stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_o = ~chain_q[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
  end
endmodule

// File: rtl/boot_phase_timer.sv
module boot_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // an expired count must rest at zero until reloaded
  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero); // R3
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_seq_pkg::*;
#(
  parameter int          IRQ_W         = 6,
  parameter int          ADDR_W        = 32,
  parameter int          SYNC_STAGES   = 5,
  parameter int          CLK_START_DLY = 8,
  parameter int          FRAME_DLY     = 525,
  parameter int          LOAD_FIXED    = 100000,
  parameter int          LOAD_PER_LINE = 50000,
  parameter int          CACHE_LINES   = 16,
  parameter int          CMD_HOLD_DLY  = 264,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 'h780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dcok,
  input  logic [IRQ_W-1:0]  irq,
  input  logic              bist_done,
  input  logic              bist_fail,
  input  logic              load_done,
  output logic              cfg_load_o,
  output logic              clk_ramp_o,
  output logic              bist_start_o,
  output logic              load_start_o,
  output logic [IRQ_W-1:0]  irq_cfg_o,
  output logic              cmd_en_o,
  output logic              fetch_o,
  output logic [ADDR_W-1:0] boot_addr_o,
  output logic              done_o,
  output logic              fail_o
);
  localparam int LOAD_DLY = LOAD_FIXED + LOAD_PER_LINE * CACHE_LINES;
  localparam int MAX_A    = (CLK_START_DLY > FRAME_DLY) ? CLK_START_DLY : FRAME_DLY;
  localparam int MAX_B    = (LOAD_DLY > CMD_HOLD_DLY) ? LOAD_DLY : CMD_HOLD_DLY;
  localparam int MAX_DLY  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_DLY + 1);

  localparam logic [CNT_W-1:0] CLK_V   = CNT_W'(CLK_START_DLY - 1);
  localparam logic [CNT_W-1:0] FRAME_V = CNT_W'(FRAME_DLY - 1);
  localparam logic [CNT_W-1:0] LOAD_V  = CNT_W'(LOAD_DLY - 1);
  localparam logic [CNT_W-1:0] CMD_V   = CNT_W'(CMD_HOLD_DLY - 1);

  logic             rst;
  phase_t           phase_q;
  logic             dcok_q;
  logic             load_seen_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             dcok_rise;
  logic             load_ok;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_o (rst)
  );

  boot_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign dcok_rise = dcok & ~dcok_q;
  assign load_ok   = load_done | load_seen_q;

  // the timer is armed on the same edge that enters each timed phase
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE:     if (dcok_rise)                         begin tmr_load = 1'b1; tmr_val = CLK_V;   end
      PH_CLKWAIT:  if (tmr_zero)                          begin tmr_load = 1'b1; tmr_val = FRAME_V; end
      PH_SELFTEST: if (!bist_fail && bist_done)           begin tmr_load = 1'b1; tmr_val = LOAD_V;  end
      PH_LOAD:     if (tmr_zero && load_ok)               begin tmr_load = 1'b1; tmr_val = CMD_V;   end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_IDLE;
      dcok_q       <= 1'b0;
      load_seen_q  <= 1'b0;
      cfg_load_o   <= 1'b0;
      clk_ramp_o   <= 1'b0;
      bist_start_o <= 1'b0;
      load_start_o <= 1'b0;
      fetch_o      <= 1'b0;
      irq_cfg_o    <= '0;
      boot_addr_o  <= '0;
      cmd_en_o     <= 1'b0;
      done_o       <= 1'b0;
      fail_o       <= 1'b0;
    end else begin
      dcok_q       <= dcok;
      cfg_load_o   <= 1'b0;
      clk_ramp_o   <= 1'b0;
      bist_start_o <= 1'b0;
      load_start_o <= 1'b0;
      fetch_o      <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (dcok_rise) begin
          irq_cfg_o  <= irq;
          cfg_load_o <= 1'b1;
          phase_q    <= PH_CLKWAIT;
        end
        PH_CLKWAIT: if (tmr_zero) begin
          clk_ramp_o <= 1'b1;
          phase_q    <= PH_RAMP;
        end
        PH_RAMP: if (tmr_zero) begin
          bist_start_o <= 1'b1;
          phase_q      <= PH_SELFTEST;
        end
        PH_SELFTEST: begin
          if (bist_fail) begin
            fail_o  <= 1'b1;
            phase_q <= PH_HALT;
          end else if (bist_done) begin
            load_start_o <= 1'b1;
            phase_q      <= PH_LOAD;
          end
        end
        PH_LOAD: begin
          if (load_done) load_seen_q <= 1'b1;
          if (tmr_zero && load_ok) begin
            fetch_o     <= 1'b1;
            done_o      <= 1'b1;
            boot_addr_o <= BOOT_ADDR;
            phase_q     <= PH_RUN;
          end
        end
        PH_RUN:  if (tmr_zero) cmd_en_o <= 1'b1;
        PH_HALT: ;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_ONE_PHASE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_load_o, clk_ramp_o, bist_start_o, load_start_o, fetch_o})); // R11
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    !cfg_load_o |-> $stable(irq_cfg_o)); // R2
  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    fetch_o |=> !fetch_o); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o); // R7
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
    fetch_o |-> (boot_addr_o == BOOT_ADDR)); // R7
  AST_CMD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    cmd_en_o |-> done_o); // R8
  AST_FAIL_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (!fetch_o && !done_o && !load_start_o)); // R9
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> fail_o); // R9
endmodule

// File: tb/boot_sequencer_tb.sv
module boot_sequencer_tb;
  localparam int IRQ_W  = 6;
  localparam int ADDR_W = 32;
  localparam int CLK_D  = 8;
  localparam int FRM_D  = 20;
  localparam int LFIX   = 30;
  localparam int LPER   = 5;
  localparam int LINES  = 4;
  localparam int LOAD_D = LFIX + LPER * LINES;
  localparam int CMD_D  = 12;
  localparam int WD_CYC = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dcok = 1'b0;
  logic [IRQ_W-1:0] irq = '0;
  logic bist_done = 1'b0, bist_fail = 1'b0, load_done = 1'b0;
  logic cfg_load_o, clk_ramp_o, bist_start_o, load_start_o, cmd_en_o, fetch_o, done_o, fail_o;
  logic [IRQ_W-1:0]  irq_cfg_o;
  logic [ADDR_W-1:0] boot_addr_o;

  always #4 clk = ~clk;

  boot_sequencer #(
    .IRQ_W(IRQ_W), .ADDR_W(ADDR_W), .SYNC_STAGES(5), .CLK_START_DLY(CLK_D),
    .FRAME_DLY(FRM_D), .LOAD_FIXED(LFIX), .LOAD_PER_LINE(LPER), .CACHE_LINES(LINES),
    .CMD_HOLD_DLY(CMD_D), .BOOT_ADDR('h780)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .dcok(dcok), .irq(irq), .bist_done(bist_done),
    .bist_fail(bist_fail), .load_done(load_done), .cfg_load_o(cfg_load_o),
    .clk_ramp_o(clk_ramp_o), .bist_start_o(bist_start_o), .load_start_o(load_start_o),
    .irq_cfg_o(irq_cfg_o), .cmd_en_o(cmd_en_o), .fetch_o(fetch_o),
    .boot_addr_o(boot_addr_o), .done_o(done_o), .fail_o(fail_o)
  );

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  int n_ev [6];
  int t_ev [6];

  always @(posedge clk) cyc <= cyc + 1;

  // event index: 0 cfg, 1 ramp, 2 selftest, 3 load, 4 fetch, 5 first cmd_en
  always @(negedge clk) begin
    if (cfg_load_o)   begin n_ev[0] <= n_ev[0] + 1; t_ev[0] <= cyc; end
    if (clk_ramp_o)   begin n_ev[1] <= n_ev[1] + 1; t_ev[1] <= cyc; end
    if (bist_start_o) begin n_ev[2] <= n_ev[2] + 1; t_ev[2] <= cyc; end
    if (load_start_o) begin n_ev[3] <= n_ev[3] + 1; t_ev[3] <= cyc; end
    if (fetch_o)      begin n_ev[4] <= n_ev[4] + 1; t_ev[4] <= cyc; end
    if (cmd_en_o && n_ev[5] == 0) begin n_ev[5] <= 1; t_ev[5] <= cyc; end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    if (cyc == WD_CYC) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD_CYC);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) step();
  endtask

  task automatic wait_evt(input int sel, input string req);
    for (int i = 0; i < 5000 && n_ev[sel] == 0; i++) step();
    if (n_ev[sel] == 0) chk(req, 32'd0, 32'd1);
  endtask

  task automatic clear_ev();
    for (int i = 0; i < 6; i++) begin n_ev[i] = 0; t_ev[i] = 0; end
  endtask

  function automatic logic [31:0] outs_word();
    return {fail_o, done_o, cmd_en_o, fetch_o, load_start_o, bist_start_o, clk_ramp_o, cfg_load_o};
  endfunction

  int rel_cyc;

  task automatic do_reset(input logic dcok_at_release);
    rst_n = 1'b0; dcok = 1'b0; irq = '0;
    bist_done = 1'b0; bist_fail = 1'b0; load_done = 1'b0;
    wait_n(3);
    chk("R10 reset outputs", outs_word(), 32'd0);
    chk("R10 reset irq word", 32'(irq_cfg_o), 32'd0);
    dcok = dcok_at_release;
    rst_n = 1'b1;
    rel_cyc = cyc;
    clear_ev();
  endtask

  task automatic t_normal_boot();
    int c;
    do_reset(1'b0);
    wait_n(8);
    irq = 6'h2D; dcok = 1'b1; c = cyc;
    wait_evt(0, "R2 cfg_load");
    chk("R2 cfg_load timing", t_ev[0], c + 1);
    chk("R2 irq captured", 32'(irq_cfg_o), 32'h2D);
    irq = 6'h12; dcok = 1'b0; step(); dcok = 1'b1; step();
    wait_evt(1, "R3 ramp");
    chk("R3 ramp delay", t_ev[1] - t_ev[0], CLK_D);
    chk("R2 irq held", 32'(irq_cfg_o), 32'h2D);
    wait_evt(2, "R4 selftest start");
    chk("R4 selftest delay", t_ev[2] - t_ev[1], FRM_D);
    wait_n(3);
    bist_done = 1'b1; c = cyc; step(); bist_done = 1'b0;
    wait_evt(3, "R5 load start");
    chk("R5 load start timing", t_ev[3], c + 1);
    load_done = 1'b1;
    wait_evt(4, "R6 fetch");
    chk("R6 fetch after load minimum", t_ev[4] - t_ev[3], LOAD_D);
    chk("R7 boot address", boot_addr_o, 32'h780);
    chk("R7 done high", 32'(done_o), 32'd1);
    wait_evt(5, "R8 cmd_en");
    chk("R8 command hold-off", t_ev[5] - t_ev[4], CMD_D);
    wait_n(4);
    chk("R11 single cfg_load", n_ev[0], 32'd1);
    chk("R7 single fetch pulse", n_ev[4], 32'd1);
    chk("R7 done sticky", 32'(done_o), 32'd1);
    chk("R8 cmd_en sticky", 32'(cmd_en_o), 32'd1);
    load_done = 1'b0;
  endtask

  task automatic t_late_load();
    int c;
    do_reset(1'b1);
    wait_evt(0, "R1 cfg after sync");
    chk("R1 synchronizer depth", t_ev[0], rel_cyc + 6);
    wait_evt(2, "R4 selftest start");
    bist_done = 1'b1; step(); bist_done = 1'b0;
    wait_evt(3, "R5 load start");
    wait_n(LOAD_D + 10);
    chk("R6 no fetch before load_done", n_ev[4], 32'd0);
    load_done = 1'b1; c = cyc;
    wait_evt(4, "R6 late fetch");
    chk("R6 fetch follows late load_done", t_ev[4], c + 1);
    load_done = 1'b0;
  endtask

  task automatic t_selftest_fail();
    do_reset(1'b1);
    wait_evt(2, "R9 selftest start");
    bist_fail = 1'b1; bist_done = 1'b1; step();
    bist_fail = 1'b0; bist_done = 1'b0; step();
    chk("R9 fail raised", 32'(fail_o), 32'd1);
    chk("R9 fail beats done", n_ev[3], 32'd0);
    load_done = 1'b1;
    wait_n(LOAD_D + CMD_D + 20);
    chk("R9 no fetch after fail", n_ev[4], 32'd0);
    chk("R9 no done after fail", 32'(done_o), 32'd0);
    chk("R9 fail sticky", 32'(fail_o), 32'd1);
    load_done = 1'b0;
  endtask

  task automatic t_mid_reset();
    do_reset(1'b0);
    wait_n(7);
    irq = 6'h3F; dcok = 1'b1;
    wait_evt(2, "R10 selftest start");
    bist_done = 1'b1; step(); bist_done = 1'b0;
    wait_evt(3, "R10 load start");
    wait_n(5);
    rst_n = 1'b0; step();
    chk("R10 mid reset outputs", outs_word(), 32'd0);
    chk("R10 mid reset irq word", 32'(irq_cfg_o), 32'd0);
    chk("R10 mid reset address", boot_addr_o, 32'd0);
    rst_n = 1'b1; rel_cyc = cyc; clear_ev();
    wait_evt(0, "R10 restart");
    chk("R10 restart from idle", t_ev[0], rel_cyc + 6);
    chk("R10 irq recaptured", 32'(irq_cfg_o), 32'h3F);
  endtask

  initial begin
    clear_ev();
    t_normal_boot();
    t_late_load();
    t_selftest_fail();
    t_mid_reset();
    summary();
    $finish;
  end
endmodule